// File: doc/BRIEF.md
# Decode-Stage Interlock for a Five-Stage Pipeline Without Forwarding

This block decides, every cycle, whether the instruction sitting in decode/register-read may move on to the ALU. The pipeline has five stages: fetch, decode/register-read, ALU, data memory and write-back. There is no operand forwarding, so a consumer must wait in decode until every older instruction that writes one of its source registers has reached write-back. The register file is written in the first half of a cycle and read in the second half. A producer that is already in write-back therefore never blocks a consumer. Only producers in the ALU and memory stages do.

While the interlock holds, decode keeps its instruction and fetch must keep offering the same one, because the program counter does not advance. A bubble with a cleared valid bit enters the ALU stage. The memory and write-back stages always advance. Each stage is modelled as a register that holds a valid bit, an instruction tag and the register numbers. This lets the stage-by-stage timing be seen at the ports. The stall output is combinational from the stage registers.

A small state machine tracks how long the current hold has lasted. The states are `ST_FLOW` (no hold in the previous cycle), `ST_HOLD1` (one held cycle) and `ST_HOLD2` (two held cycles). The transitions are:
- FLOW→HOLD1 when a stall is raised.
- HOLD1→HOLD2 when the stall persists.
- Any state→FLOW when the stall drops.

Top module: `ilk_interlock`

## Requirements
- R1: Reset, whenever asserted, clears the valid bits of the decode, ALU, memory and write-back stages, and the stall output is low afterwards.
- R2: Stall is high when the valid decode instruction has a nonzero source register equal to the destination of the valid instruction in the ALU stage.
- R3: Stall is high when the valid decode instruction has a nonzero source register equal to the destination of the valid instruction in the memory stage.
- R4: A producer in the write-back stage never causes a stall.
- R5: Register number 0 is never a dependence, whether it appears as a source or as a destination.
- R6: The first source (`f_rs1`) and the second source (`f_rs2`) are compared independently, and the stall is raised if either of them matches.
- R7: While stall is high, decode keeps the same instruction (same valid bit and tag), and the instruction offered at fetch is not taken.
- R8: The cycle after a stalled cycle, the ALU stage holds a bubble (valid low).
- R9: A consumer placed d positions after its producer (d = 1, 2, 3) stays in decode for 1 + max(0, 3 − d) cycles. An adjacent dependent therefore enters the ALU two cycles late, and a hold never lasts more than two cycles.
- R10: Every instruction moves from the ALU stage to the memory stage and then to write-back on consecutive cycles, and instructions retire in program order with none lost or duplicated.
- R11: An independent instruction that follows a stalled one enters the ALU exactly one cycle after it.
- R12: An invalid entry in decode never raises the stall, whatever register numbers it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | The instruction offered at fetch is valid |
| f_tag | input | TAG_W | Identifier of the fetched instruction |
| f_rs1 | input | REG_W | First source register of the fetched instruction |
| f_rs2 | input | REG_W | Second source register of the fetched instruction |
| f_rd | input | REG_W | Destination register of the fetched instruction (0 = none) |
| stall | output | 1 | Holds fetch and decode and inserts an ALU bubble |
| d_valid | output | 1 | Decode stage occupied |
| d_tag | output | TAG_W | Tag in decode |
| a_valid | output | 1 | ALU stage occupied |
| a_tag | output | TAG_W | Tag in ALU |
| m_valid | output | 1 | Memory stage occupied |
| m_tag | output | TAG_W | Tag in memory |
| w_valid | output | 1 | Write-back stage occupied |
| w_tag | output | TAG_W | Tag in write-back |

## Verification
The hardest case to reach is a consumer whose producer is exactly at the edge of the blocking window. The producer must sit in the memory stage, or be just leaving for write-back, while the consumer arrives in decode. The timing of that arrival depends on the earlier holds. The bench sweeps every producer destination against every pair of source registers in a four-register configuration, at distances one, two and three. It spaces the instructions with independent fillers and feeds fetch only when the stall is low. From each run it measures the decode residence time, the ALU entry cycle, the bubble pattern, the timing of the follower and the retirement order. Directed runs add an invalid decode entry that carries matching registers, and a reset asserted in the middle of a hold.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    // Number of source operands compared per decode instruction.
    localparam int NUM_SRC = 2;
    // Stages whose producers can block decode: ALU and data memory.
    localparam int NUM_BLK = 2;

    typedef enum logic [1:0] {
        ST_FLOW  = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLD2 = 2'd2
    } hold_st_e;
endpackage

// File: rtl/ilk_match.sv
module ilk_match #(
    parameter int REG_W  = 5,
    parameter int N_PROD = 2
) (
    input  logic [REG_W-1:0]             src,
    input  logic [N_PROD-1:0]            prod_valid,
    input  logic [N_PROD-1:0][REG_W-1:0] prod_rd,
    output logic                         hit
);
    logic [N_PROD-1:0] eq;
    logic              src_live;

    // Register 0 is hard-wired, never a true dependence.
    assign src_live = (src != '0);

    for (genvar g = 0; g < N_PROD; g++) begin : g_prod
        assign eq[g] = src_live && prod_valid[g] && (prod_rd[g] == src);
    end

    assign hit = |eq;
endmodule

// File: rtl/ilk_stall_fsm.sv
module ilk_stall_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_busy,
    input  logic dep_hit,
    output logic stall,
    output logic dec_load,
    output logic alu_bubble
);
    import ilk_pkg::*;

    hold_st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLOW;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_FLOW:  state_nx = stall ? ST_HOLD1 : ST_FLOW;
            ST_HOLD1: state_nx = stall ? ST_HOLD2 : ST_FLOW;
            ST_HOLD2: state_nx = stall ? ST_HOLD2 : ST_FLOW;
            default:  state_nx = ST_FLOW;
        endcase
    end

    always_comb begin
        stall      = dec_busy && dep_hit;
        dec_load   = !stall;
        alu_bubble = stall;
    end

    // Without forwarding, a hold can never exceed two cycles.
    assert_hold_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD2) |-> !stall);

    // A stall only ever comes from a valid decode entry.
    assert_idle_no_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_busy |-> !stall);
endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock #(
    parameter int REG_W = 5,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             f_valid,
    input  logic [TAG_W-1:0] f_tag,
    input  logic [REG_W-1:0] f_rs1,
    input  logic [REG_W-1:0] f_rs2,
    input  logic [REG_W-1:0] f_rd,
    output logic             stall,
    output logic             d_valid,
    output logic [TAG_W-1:0] d_tag,
    output logic             a_valid,
    output logic [TAG_W-1:0] a_tag,
    output logic             m_valid,
    output logic [TAG_W-1:0] m_tag,
    output logic             w_valid,
    output logic [TAG_W-1:0] w_tag
);
    import ilk_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rd;
    } dec_slot_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] rd;
    } prod_slot_t;

    dec_slot_t  f_s, d_q;
    prod_slot_t a_q, m_q;
    logic             w_vq;
    logic [TAG_W-1:0] w_tq;

    logic [NUM_SRC-1:0][REG_W-1:0] src_vec;
    logic [NUM_BLK-1:0]            blk_valid;
    logic [NUM_BLK-1:0][REG_W-1:0] blk_rd;
    logic [NUM_SRC-1:0]            src_hit;
    logic                          dec_load, alu_bubble;

    assign f_s       = '{valid: f_valid, tag: f_tag, rs1: f_rs1, rs2: f_rs2, rd: f_rd};
    assign src_vec   = {d_q.rs2, d_q.rs1};
    assign blk_valid = {m_q.valid, a_q.valid};
    assign blk_rd    = {m_q.rd, a_q.rd};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        ilk_match #(.REG_W(REG_W), .N_PROD(NUM_BLK)) u_match (
            .src        (src_vec[s]),
            .prod_valid (blk_valid),
            .prod_rd    (blk_rd),
            .hit        (src_hit[s])
        );
    end

    ilk_stall_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_busy   (d_q.valid),
        .dep_hit    (|src_hit),
        .stall      (stall),
        .dec_load   (dec_load),
        .alu_bubble (alu_bubble)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q  <= '0;
            a_q  <= '0;
            m_q  <= '0;
            w_vq <= 1'b0;
            w_tq <= '0;
        end else begin
            if (dec_load) d_q <= f_s;
            if (alu_bubble) a_q <= '0;
            else            a_q <= '{valid: d_q.valid, tag: d_q.tag, rd: d_q.rd};
            m_q  <= a_q;
            w_vq <= m_q.valid;
            w_tq <= m_q.tag;
        end
    end

    assign d_valid = d_q.valid;
    assign d_tag   = d_q.tag;
    assign a_valid = a_q.valid;
    assign a_tag   = a_q.tag;
    assign m_valid = m_q.valid;
    assign m_tag   = m_q.tag;
    assign w_valid = w_vq;
    assign w_tag   = w_tq;

    assert_bubble_after_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !a_valid);

    assert_decode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (d_valid == $past(d_valid)) && (d_tag == $past(d_tag)));

    assert_alu_to_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |=> m_valid && (m_tag == $past(a_tag)));

    assert_mem_to_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |=> w_valid && (w_tag == $past(m_tag)));

    assert_zero_sources_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.rs1 == '0 && d_q.rs2 == '0) |-> !stall);
endmodule

// File: tb/test_ilk_interlock.sv
`timescale 1ns/1ps
module test_ilk_interlock;
    localparam int RW = 2;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          f_valid = 1'b0;
    logic [TW-1:0] f_tag = '0;
    logic [RW-1:0] f_rs1 = '0, f_rs2 = '0, f_rd = '0;
    logic          stall, d_valid, a_valid, m_valid, w_valid;
    logic [TW-1:0] d_tag, a_tag, m_tag, w_tag;

    int errors = 0;
    int checks = 0;

    int s_val [0:15];
    int s_rs1 [0:15];
    int s_rs2 [0:15];
    int s_rd  [0:15];

    always #5 clk = ~clk;

    ilk_interlock #(.REG_W(RW), .TAG_W(TW)) i_ilk_interlock (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_tag(f_tag),
        .f_rs1(f_rs1), .f_rs2(f_rs2), .f_rd(f_rd), .stall(stall),
        .d_valid(d_valid), .d_tag(d_tag), .a_valid(a_valid), .a_tag(a_tag),
        .m_valid(m_valid), .m_tag(m_tag), .w_valid(w_valid), .w_tag(w_tag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int idx, input int len);
        if (idx < len) begin
            f_valid = (s_val[idx] != 0);
            f_tag   = TW'(idx);
            f_rs1   = RW'(s_rs1[idx]);
            f_rs2   = RW'(s_rs2[idx]);
            f_rd    = RW'(s_rd[idx]);
        end else begin
            f_valid = 1'b0; f_tag = '0; f_rs1 = '0; f_rs2 = '0; f_rd = '0;
        end
    endtask

    task automatic set_item(input int i, input int rs1, input int rs2, input int rd);
        s_val[i] = 1; s_rs1[i] = rs1; s_rs2[i] = rs2; s_rd[i] = rd;
    endtask

    task automatic run_case(input int len, input int cidx,
                            output int stalls, output int cyc_a, output int cyc_w,
                            output int cyc_fa, output int bub_bad, output int hold_bad,
                            output int ord_bad, output int retired);
        int  idx = 0;
        bit  prev_stall = 1'b0;
        int  prev_dtag = 0;
        bit  prev_dval = 1'b0;
        bit  cons;
        stalls = 0; cyc_a = -1; cyc_w = -1; cyc_fa = -1;
        bub_bad = 0; hold_bad = 0; ord_bad = 0; retired = 0;
        @(negedge clk);
        drive(0, len);
        for (int t = 0; t < len + 12; t++) begin
            cons = !stall;
            @(posedge clk);
            @(negedge clk);
            if (cons) begin
                idx++;
                drive(idx, len);
            end
            if (prev_stall && a_valid) bub_bad++;
            if (prev_stall && (d_valid != prev_dval || int'(d_tag) != prev_dtag)) hold_bad++;
            if (d_valid && int'(d_tag) == cidx && stall) stalls++;
            if (a_valid && int'(a_tag) == cidx) cyc_a = t;
            if (a_valid && int'(a_tag) == cidx + 1) cyc_fa = t;
            if (w_valid && int'(w_tag) == cidx) cyc_w = t;
            if (w_valid) begin
                if (int'(w_tag) != retired) ord_bad++;
                retired++;
            end
            prev_stall = stall;
            prev_dtag  = int'(d_tag);
            prev_dval  = d_valid;
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int stalls, cyc_a, cyc_w, cyc_fa, bub_bad, hold_bad, ord_bad, retired;
        int len, exp_st, highs;
        bit dep;
        string req;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!d_valid && !a_valid && !m_valid && !w_valid, "R1", "valids in reset",
              int'({d_valid, a_valid, m_valid, w_valid}), 0);
        check(!stall, "R1", "stall in reset", int'(stall), 0);
        rst_n = 1'b1;

        for (int k = 1; k <= 3; k++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int b = 0; b < 4; b++) begin
                        len = k + 4;
                        for (int i = 0; i < len; i++) set_item(i, 0, 0, 0);
                        set_item(0, 0, 0, p);
                        set_item(k, a, b, 0);
                        run_case(len, k, stalls, cyc_a, cyc_w, cyc_fa,
                                 bub_bad, hold_bad, ord_bad, retired);
                        dep    = (p != 0) && (a == p || b == p);
                        exp_st = dep ? (3 - k) : 0;
                        if (k == 3)             req = "R4";
                        else if (p == 0)        req = "R5";
                        else if (dep && a != p) req = "R6";
                        else if (dep)           req = (k == 1) ? "R2" : "R3";
                        else                    req = "R6";
                        check(stalls == exp_st, req, "stall cycles", stalls, exp_st);
                        check(cyc_a == k + 1 + exp_st, "R9", "ALU entry cycle",
                              cyc_a, k + 1 + exp_st);
                        check(cyc_fa == cyc_a + 1, "R11", "follower ALU entry",
                              cyc_fa, cyc_a + 1);
                        check(cyc_w == cyc_a + 2, "R10", "write-back cycle",
                              cyc_w, cyc_a + 2);
                        check(ord_bad == 0 && retired == len, "R10", "retired in order",
                              retired, len);
                        check(bub_bad == 0, "R8", "bubble after stall", bub_bad, 0);
                        check(hold_bad == 0, "R7", "decode held", hold_bad, 0);
                    end
                end
            end
        end

        // R12: invalid decode entry carrying a matching source.
        for (int i = 0; i < 6; i++) set_item(i, 0, 0, 0);
        set_item(0, 0, 0, 1);
        s_val[1] = 0; s_rs1[1] = 1; s_rs2[1] = 1;
        @(negedge clk);
        drive(0, 6);
        highs = 0;
        for (int t = 0; t < 8; t++) begin
            @(posedge clk);
            @(negedge clk);
            drive(t + 1, 6);
            if (stall) highs++;
        end
        check(highs == 0, "R12", "stall from invalid decode", highs, 0);

        // R1: reset in the middle of a hold.
        for (int i = 0; i < 2; i++) set_item(i, 0, 0, 0);
        set_item(0, 0, 0, 3);
        set_item(1, 3, 0, 0);
        @(negedge clk);
        drive(0, 2);
        @(posedge clk);
        @(negedge clk);
        drive(1, 2);
        @(posedge clk);
        @(negedge clk);
        check(stall, "R2", "adjacent dependent stalls", int'(stall), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!d_valid && !a_valid && !m_valid && !w_valid && !stall, "R1",
              "state after mid-run reset",
              int'({d_valid, a_valid, m_valid, w_valid, stall}), 0);
        drive(5, 2);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!stall && !a_valid, "R1", "quiet after reset release",
              int'({stall, a_valid}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule